// File: doc/BRIEF.md
# Halfword byte-swapping DMA bridge

This bridge moves data between a 16-bit peripheral and a byte-addressed memory port. The peripheral asks for a transfer by giving a direction, a start address and a byte count. The bridge ORs a base value into the address and then issues one 16-bit beat per memory request. In the default swap mode it forces the address and the count to even values and exchanges the two bytes of every halfword. This applies to write data going to memory and to read data returning to the peripheral. When the no-swap input is high, address, count and data pass unchanged.

Swapped writes are cut into bursts of at most 64 bytes. The memory port marks the last beat of each burst, and the address keeps counting up across the burst boundaries. Reads keep one request in flight: each request beat waits for its response before the next beat goes out. Backpressure on the memory port stalls the bridge with the beat held in place. A busy flag covers the whole request, and a single-cycle done pulse follows the last beat.

Top module: `hwswap_bridge`

## Requirements
- R1: The address of beat k is (reqAddr OR base) + 2k. The base is a register loaded from baseIn in the cycle after baseWe is sampled high, and it resets to zero.
- R2: In swap mode (noSwap low), bit 0 of the ORed address and bit 0 of the byte count are cleared before the transfer starts. A count of 5 therefore gives two beats starting at an even address.
- R3: In a swap-mode write, memReqData equals perWrData with its upper and lower bytes exchanged.
- R4: In a swap-mode read, perRdData equals memRspData with its upper and lower bytes exchanged. It is presented while perRdValid is high, in the cycle that the response arrives.
- R5: In no-swap mode, address, count and data are unchanged. memBytes is 2 for a full beat and 1 for a final odd byte, which is carried in data bits 7:0.
- R6: In a swap-mode write, memLast is high on beat k when k mod 32 = 31 (the end of a 64-byte burst) and on the final beat. On other beats it is low. A no-swap write or a read asserts memLast only on its final beat.
- R7: While memReqValid is high and memReqReady is low, the beat does not advance and its address is held. Every beat is transferred exactly once.
- R8: A request whose effective count is zero raises done in the next cycle and never raises memReqValid.
- R9: After reset, busy, done and memReqValid are low. Busy is high from the cycle after a request is accepted through the done cycle. Done is high for one cycle, the cycle after the last beat completes. A reqValid seen while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| baseWe | input | 1 | Load the base register |
| baseIn | input | 32 | New base value |
| reqValid | input | 1 | Request strobe, taken when not busy |
| reqWrite | input | 1 | 1 = write to memory, 0 = read from memory |
| noSwap | input | 1 | 1 = pass through, 0 = byte-swap and even alignment |
| reqAddr | input | 32 | Start byte address |
| reqLen | input | 16 | Byte count |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| perWrValid | input | 1 | Peripheral write beat valid |
| perWrData | input | 16 | Peripheral write beat |
| perWrReady | output | 1 | Peripheral write beat taken |
| perRdValid | output | 1 | Read beat to the peripheral valid |
| perRdData | output | 16 | Read beat to the peripheral |
| memReqValid | output | 1 | Memory beat request |
| memReqReady | input | 1 | Memory accepts the beat |
| memReqWrite | output | 1 | Beat is a write |
| memReqAddr | output | 32 | Beat byte address |
| memReqData | output | 16 | Beat write data |
| memBytes | output | 2 | Bytes in this beat (1 or 2) |
| memLast | output | 1 | Last beat of a burst or of the request |
| memRspValid | input | 1 | Read response valid |
| memRspData | input | 16 | Read response data |

## Verification
Transfers are run with odd and even addresses and counts. Each is run with a zero base and with a nonzero base, so that the ORed base and the cleared bit 0 are visible separately. Swap and pass-through runs use the same data pattern, which has distinct upper and lower bytes, so an exchange that is missing or wrong shows in the data. A 130-byte swapped write crosses two burst boundaries and a 70-byte pass-through write crosses none, which tells the burst rule apart from a plain beat count. Runs with periodic backpressure, zero and one-byte counts, and a request raised while busy cover the stall, immediate-done and ignore paths.

// File: rtl/hwswap_pkg.sv
package hwswap_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_WR, ST_RDREQ, ST_RDWAIT, ST_FIN} state_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;  // capture a new request
    logic step;  // one beat has completed
  } dpStrobe_t;

  function automatic logic [15:0] swapHalf(input logic [15:0] v);
    return {v[7:0], v[15:8]};
  endfunction
endpackage

// File: rtl/hwswap_dp.sv
module hwswap_dp
  import hwswap_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int LEN_W       = 16,
  parameter int CHUNK_BYTES = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic              baseWe,
  input  logic [ADDR_W-1:0] baseIn,
  input  logic              reqWrite,
  input  logic              noSwap,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [LEN_W-1:0]  reqLen,
  input  logic [15:0]       perWrData,
  input  logic [15:0]       memRspData,
  input  logic              memReqValid,
  input  logic              memReqReady,
  output logic              zeroLen,
  output logic              lastBeat,
  output logic [ADDR_W-1:0] memReqAddr,
  output logic [15:0]       memReqData,
  output logic [1:0]        memBytes,
  output logic              memLast,
  output logic [15:0]       perRdData
);
  localparam int CHUNK_BEATS = CHUNK_BYTES / 2;
  localparam int CW = (CHUNK_BEATS > 1) ? $clog2(CHUNK_BEATS) : 1;

  logic [ADDR_W-1:0] baseReg, curAddr, effAddr;
  logic [LEN_W-1:0]  remBytes, effLen;
  logic [CW-1:0]     chunkCnt;
  logic              swapQ, writeQ, chunkEnd;

  assign effAddr = (reqAddr | baseReg) & ~{{(ADDR_W-1){1'b0}}, ~noSwap};
  assign effLen  = reqLen & ~{{(LEN_W-1){1'b0}}, ~noSwap};
  assign zeroLen = (effLen == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) baseReg <= '0;
    else if (baseWe) baseReg <= baseIn;
  end

  assign lastBeat = (remBytes <= LEN_W'(2));
  assign chunkEnd = (chunkCnt == CW'(CHUNK_BEATS - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curAddr  <= '0;
      remBytes <= '0;
      chunkCnt <= '0;
      swapQ    <= 1'b0;
      writeQ   <= 1'b0;
    end else if (strobe.load) begin
      curAddr  <= effAddr;
      remBytes <= effLen;
      chunkCnt <= '0;
      swapQ    <= ~noSwap;
      writeQ   <= reqWrite;
    end else if (strobe.step) begin
      curAddr  <= curAddr + ADDR_W'(2);
      remBytes <= lastBeat ? '0 : remBytes - LEN_W'(2);
      chunkCnt <= chunkEnd ? '0 : chunkCnt + CW'(1);
    end
  end

  assign memReqAddr = curAddr;
  assign memBytes   = (remBytes >= LEN_W'(2)) ? 2'd2 : 2'd1;
  assign memLast    = lastBeat | (swapQ & writeQ & chunkEnd);
  assign memReqData = swapQ ? swapHalf(perWrData) : perWrData;
  assign perRdData  = swapQ ? swapHalf(memRspData) : memRspData;

  // Independent burst-length counter for checking
  logic [LEN_W-1:0] sinceLast;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sinceLast <= '0;
    else if (strobe.load) sinceLast <= '0;
    else if (memReqValid && memReqReady) sinceLast <= memLast ? '0 : sinceLast + LEN_W'(1);
  end

  a_r6_burst_bound: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && memReqReady && swapQ && writeQ) |-> (sinceLast < LEN_W'(CHUNK_BEATS)));
  a_r2_even_addr: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && swapQ) |-> (memReqAddr[0] == 1'b0));
  a_r7_hold_addr: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=> $stable(memReqAddr));
endmodule

// File: rtl/hwswap_ctrl.sv
module hwswap_ctrl
  import hwswap_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      reqWrite,
  input  logic      zeroLen,
  input  logic      lastBeat,
  input  logic      perWrValid,
  input  logic      memReqReady,
  input  logic      memRspValid,
  output dpStrobe_t strobe,
  output logic      busy,
  output logic      done,
  output logic      memReqValid,
  output logic      memReqWrite,
  output logic      perWrReady,
  output logic      perRdValid
);
  state_t state, nextState;

  always_comb begin
    strobe.load = (state == ST_IDLE) && reqValid;
    strobe.step = ((state == ST_WR) && perWrValid && memReqReady) ||
                  ((state == ST_RDWAIT) && memRspValid);
    nextState = state;
    case (state)
      ST_IDLE:   if (reqValid) nextState = zeroLen ? ST_FIN : (reqWrite ? ST_WR : ST_RDREQ);
      ST_WR:     if (strobe.step && lastBeat) nextState = ST_FIN;
      ST_RDREQ:  if (memReqReady) nextState = ST_RDWAIT;
      ST_RDWAIT: if (memRspValid) nextState = lastBeat ? ST_FIN : ST_RDREQ;
      ST_FIN:    nextState = ST_IDLE;
      default:   nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else state <= nextState;
  end

  assign busy        = (state != ST_IDLE);
  assign done        = (state == ST_FIN);
  assign memReqValid = ((state == ST_WR) && perWrValid) || (state == ST_RDREQ);
  assign memReqWrite = (state == ST_WR);
  assign perWrReady  = (state == ST_WR) && memReqReady;
  assign perRdValid  = (state == ST_RDWAIT) && memRspValid;

  a_r9_done_releases: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busy);
  a_r9_mem_only_busy: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> busy);
  a_r8_zero_done: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && reqValid && zeroLen) |=> (done && !memReqValid));
endmodule

// File: rtl/hwswap_bridge.sv
module hwswap_bridge
  import hwswap_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int LEN_W       = 16,
  parameter int CHUNK_BYTES = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              baseWe,
  input  logic [ADDR_W-1:0] baseIn,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic              noSwap,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [LEN_W-1:0]  reqLen,
  output logic              busy,
  output logic              done,
  input  logic              perWrValid,
  input  logic [15:0]       perWrData,
  output logic              perWrReady,
  output logic              perRdValid,
  output logic [15:0]       perRdData,
  output logic              memReqValid,
  input  logic              memReqReady,
  output logic              memReqWrite,
  output logic [ADDR_W-1:0] memReqAddr,
  output logic [15:0]       memReqData,
  output logic [1:0]        memBytes,
  output logic              memLast,
  input  logic              memRspValid,
  input  logic [15:0]       memRspData
);
  dpStrobe_t strobe;
  logic      zeroLen, lastBeat;

  hwswap_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .zeroLen(zeroLen), .lastBeat(lastBeat), .perWrValid(perWrValid),
    .memReqReady(memReqReady), .memRspValid(memRspValid), .strobe(strobe),
    .busy(busy), .done(done), .memReqValid(memReqValid),
    .memReqWrite(memReqWrite), .perWrReady(perWrReady), .perRdValid(perRdValid)
  );

  hwswap_dp #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .CHUNK_BYTES(CHUNK_BYTES)) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .baseWe(baseWe), .baseIn(baseIn),
    .reqWrite(reqWrite), .noSwap(noSwap), .reqAddr(reqAddr), .reqLen(reqLen),
    .perWrData(perWrData), .memRspData(memRspData), .memReqValid(memReqValid),
    .memReqReady(memReqReady), .zeroLen(zeroLen), .lastBeat(lastBeat),
    .memReqAddr(memReqAddr), .memReqData(memReqData), .memBytes(memBytes),
    .memLast(memLast), .perRdData(perRdData)
  );
endmodule

// File: tb/test_hwswap_bridge.sv
`timescale 1ns/1ps
module test_hwswap_bridge;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        baseWe = 1'b0;
  logic [31:0] baseIn = '0;
  logic        reqValid = 1'b0, reqWrite = 1'b0, noSwap = 1'b0;
  logic [31:0] reqAddr = '0;
  logic [15:0] reqLen = '0;
  logic        busy, done;
  logic        perWrValid = 1'b0;
  logic [15:0] perWrData = '0;
  logic        perWrReady, perRdValid;
  logic [15:0] perRdData;
  logic        memReqValid, memReqWrite, memLast;
  logic        memReqReady = 1'b0;
  logic [31:0] memReqAddr;
  logic [15:0] memReqData;
  logic [1:0]  memBytes;
  logic        memRspValid = 1'b0;
  logic [15:0] memRspData = '0;

  always #4 clk = ~clk;  // 125 MHz

  hwswap_bridge i_hwswap_bridge (.*);

  int nChecks = 0, nFail = 0;
  bit finished = 1'b0;

  typedef struct packed {
    logic [31:0] base;
    logic        wr;
    logic        ns;
    logic [31:0] addr;
    logic [15:0] len;
    logic [3:0]  stall;
  } vec_t;

  localparam int NVEC = 9;
  localparam vec_t VECS [NVEC] = '{
    '{32'h0000_0000, 1'b1, 1'b0, 32'h0000_1000, 16'd8,   4'd0},
    '{32'h00F0_0000, 1'b1, 1'b0, 32'h0000_1003, 16'd7,   4'd0},
    '{32'h0000_0000, 1'b0, 1'b0, 32'h0000_2000, 16'd6,   4'd0},
    '{32'h0010_0000, 1'b0, 1'b1, 32'h0000_2001, 16'd5,   4'd0},
    '{32'h0000_0000, 1'b1, 1'b1, 32'h0000_3000, 16'd70,  4'd3},
    '{32'h0000_0000, 1'b1, 1'b0, 32'h0000_4000, 16'd130, 4'd2},
    '{32'h0000_0000, 1'b0, 1'b0, 32'h0000_5001, 16'd4,   4'd2},
    '{32'h0000_0000, 1'b1, 1'b0, 32'h0000_6000, 16'd0,   4'd0},
    '{32'h0000_0000, 1'b1, 1'b0, 32'h0000_7000, 16'd1,   4'd0}
  };

  function automatic logic [15:0] sw16(input logic [15:0] v);
    return {v[7:0], v[15:8]};
  endfunction
  function automatic logic [15:0] wrPat(input int b);
    return {8'(b) ^ 8'h5A, 8'(b)};
  endfunction
  function automatic logic [15:0] memPat(input logic [31:0] a);
    return a[15:0] ^ 16'h3C96;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic loadBase(input logic [31:0] v);
    @(negedge clk); baseWe = 1'b1; baseIn = v;
    @(negedge clk); baseWe = 1'b0;
  endtask

  // Runs one transfer; we are at a negedge on entry and on exit.
  task automatic runXfer(input logic [31:0] base, input bit wr, input bit ns,
                         input logic [31:0] a, input logic [15:0] l,
                         input int stall, input bit intrude);
    logic [31:0] ea, prevAddr;
    int el, nBeats, beat, cyc;
    bit sw, held;
    sw = !ns;
    ea = (a | base) & ~{31'd0, sw};
    el = int'(l & ~{15'd0, sw});
    nBeats = (el + 1) / 2;
    reqValid = 1'b1; reqWrite = wr; noSwap = ns; reqAddr = a; reqLen = l;
    @(negedge clk);
    reqValid = 1'b0;
    chk("R9 busy after accept", {31'd0, busy}, 32'd1);
    if (el == 0) begin
      chk("R8 zero-length done", {31'd0, done}, 32'd1);
      chk("R8 zero-length no memory request", {31'd0, memReqValid}, 32'd0);
    end else begin
      beat = 0; cyc = 0; held = 1'b0;
      while (beat < nBeats && cyc < 2000) begin
        cyc++;
        memReqReady = (stall == 0) || ((cyc % stall) != 0);
        if (intrude && cyc == 1) begin
          reqValid = 1'b1; reqAddr = 32'h0000_9000; reqLen = 16'd0;
        end else reqValid = 1'b0;
        if (wr) begin
          perWrValid = 1'b1;
          perWrData = wrPat(beat);
        end
        #1;
        if (held) chk("R7 address held under backpressure", memReqAddr, prevAddr);
        held = 1'b0;
        if (memReqValid && !memReqReady) begin
          held = 1'b1; prevAddr = memReqAddr;
          @(negedge clk);
        end else if (memReqValid) begin
          chk(sw ? "R1/R2 beat address" : "R1/R5 beat address", memReqAddr, ea + 32'(2 * beat));
          chk("R5 beat byte count", {30'd0, memBytes}, (el - 2 * beat >= 2) ? 32'd2 : 32'd1);
          chk("R6 burst last flag", {31'd0, memLast},
              {31'd0, (beat == nBeats - 1) || (sw && wr && (beat % 32) == 31)});
          chk("R9 write direction", {31'd0, memReqWrite}, {31'd0, wr});
          if (wr) begin
            chk(sw ? "R3 swapped write data" : "R5 passthrough write data",
                {16'd0, memReqData}, {16'd0, sw ? sw16(wrPat(beat)) : wrPat(beat)});
            @(negedge clk);
          end else begin
            @(negedge clk);
            memReqReady = 1'b0;
            memRspValid = 1'b1;
            memRspData = memPat(ea + 32'(2 * beat));
            #1;
            chk("R4 read valid", {31'd0, perRdValid}, 32'd1);
            chk(sw ? "R4 swapped read data" : "R5 passthrough read data",
                {16'd0, perRdData},
                {16'd0, sw ? sw16(memPat(ea + 32'(2 * beat))) : memPat(ea + 32'(2 * beat))});
            @(negedge clk);
            memRspValid = 1'b0;
          end
          beat++;
        end else begin
          @(negedge clk);
        end
      end
      reqValid = 1'b0;
      perWrValid = 1'b0;
      memReqReady = 1'b0;
      chk("R7 all beats transferred", 32'(beat), 32'(nBeats));
      chk("R9 done after last beat", {31'd0, done}, 32'd1);
    end
    @(negedge clk);
    chk("R9 done is one cycle", {31'd0, done}, 32'd0);
    chk("R9 busy released", {31'd0, busy}, 32'd0);
    chk("R9 intruding request ignored", {31'd0, memReqValid}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 reset busy", {31'd0, busy}, 32'd0);
    chk("R9 reset done", {31'd0, done}, 32'd0);
    chk("R9 reset memReqValid", {31'd0, memReqValid}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    for (int i = 0; i < NVEC; i++) begin
      loadBase(VECS[i].base);
      runXfer(VECS[i].base, VECS[i].wr, VECS[i].ns, VECS[i].addr, VECS[i].len,
              int'(VECS[i].stall), 1'b0);
    end
    // Directed: request raised while busy must be ignored
    loadBase(32'h0000_0000);
    runXfer(32'h0000_0000, 1'b1, 1'b0, 32'h0000_A000, 16'd6, 2, 1'b1);
    // Directed: base written, then a read with base ORed and odd address
    loadBase(32'h0300_0000);
    runXfer(32'h0300_0000, 1'b0, 1'b0, 32'h0000_0105, 16'd3, 0, 1'b0);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end
endmodule